// File: doc/BRIEF.md
# Character Raster Timing Generator

This block produces the beam timing for a display that is organised as a grid of character cells. It is clocked once per character and derives, from a set of static programmed values, the horizontal and vertical sync pulses, a display-enable window, the scanline number inside the current character row (raster address) and a 14-bit memory address that walks through the character codes of the screen. A frame consists of a programmable number of character rows, each a programmable number of scanlines tall. An optional run of extra scanlines follows the last row to trim the frame height.

The memory address is reloaded from a programmed start value at the top of every frame. Along a scanline it steps once per displayed character. Each scanline of a row begins again from a row-base register, and that register moves on to the address after the row's last displayed character when the row's final scanline ends. The display-enable output can be skewed later by up to two characters to match a downstream fetch pipeline, or it can be forced off. Three scan modes are offered: progressive, interlace with a half-line vsync offset in alternate fields, and interlace with the sync offset where alternate fields also show odd or even scanlines. The configuration inputs are expected to hold steady between resets.

Top module: `char_raster_timer`

## Requirements
- R1: A scanline lasts cfg_h_total+1 character clocks (positions 0..cfg_h_total). Horizontal display is active for positions below cfg_h_disp.
- R2: hsync rises at position cfg_hs_pos and stays high for W characters, where W is cfg_hs_width and a code of 0 means 16. The pulse may continue past the end of a line into the next line.
- R3: Each character row has cfg_row_max+1 scanlines, and ras_addr counts them from 0. A frame has cfg_v_total+1 rows followed by cfg_v_adj extra scanlines, during which ras_addr counts 0..cfg_v_adj-1.
- R4: Vertical display is active in rows below cfg_v_disp and never during the extra scanlines. disp_en (before skew) is the AND of the horizontal and vertical windows.
- R5: vsync rises at the first scanline of row cfg_vs_pos and stays high for W scanlines, where W is cfg_vs_width and a code of 0 means 16.
- R6: mem_addr is cfg_start_addr + row*cfg_h_disp + min(position, cfg_h_disp), modulo 2^14. In this formula, row counts the character rows of the frame, and the extra scanlines use cfg_v_total+1.
- R7: cfg_skew codes 0, 1 and 2 delay disp_en by that many character clocks relative to the other outputs. Code 3 holds disp_en low.
- R8: Bit 0 of cfg_scan_mode selects interlace (codes 00 and 10 are progressive). In interlace the field flips at each frame end and starts at 0 after reset. In field 1, vsync is delayed by floor((cfg_h_total+1)/2) characters.
- R9: In mode 11, ras_addr steps by 2 from 0 in field 0 and from 1 in field 1. A row ends at the scanline where ras_addr+1 >= cfg_row_max.
- R10: All outputs are registered and show the timing position of the previous clock. During reset every output is 0. The first clock after reset shows position 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_h_total | input | 8 | Line length minus one, in characters |
| cfg_h_disp | input | 8 | Displayed characters per line |
| cfg_hs_pos | input | 8 | Character position where hsync rises |
| cfg_hs_width | input | 4 | hsync width in characters, 0 means 16 |
| cfg_vs_width | input | 4 | vsync width in scanlines, 0 means 16 |
| cfg_v_total | input | 7 | Rows per frame minus one |
| cfg_v_disp | input | 7 | Displayed rows per frame |
| cfg_vs_pos | input | 7 | Row where vsync rises |
| cfg_row_max | input | 5 | Scanlines per row minus one |
| cfg_v_adj | input | 5 | Extra scanlines after the last row |
| cfg_skew | input | 2 | disp_en delay code, 3 blanks |
| cfg_scan_mode | input | 2 | Scan mode: bit 0 interlace, 11 adds alternate-scanline video |
| cfg_start_addr | input | 14 | Memory address at top of frame |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable after skew |
| ras_addr | output | 5 | Scanline within the current row |
| mem_addr | output | 14 | Character memory address |

## Verification
The bench builds the block with its default parameters: 8-bit horizontal counters, 7-bit row counters, a 5-bit raster address, a 14-bit address and a maximum skew of two. It programs short lines and only a few rows, so that several whole frames, and with them both interlace fields, fit into a few hundred cycles. These small totals still reach an hsync that wraps across the end of a line, width code 0 for both syncs, a vsync that runs to the very last scanline of a frame, and a start address near the top of the 14-bit space so that the address wraps. The scoreboard predicts each output from the timing position alone, and it covers all four skew codes and all three scan-mode behaviours.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

  localparam int SYNC_W     = 4;
  localparam int SYNC_CNT_W = SYNC_W + 1;

  typedef enum logic [1:0] {
    SCAN_PROG        = 2'b00,
    SCAN_ILACE_SYNC  = 2'b01,
    SCAN_PROG_ALT    = 2'b10,
    SCAN_ILACE_VIDEO = 2'b11
  } scan_mode_e;

  localparam logic [1:0] SKEW_BLANK = 2'd3;

  // Width code 0 stands for the largest pulse, 2**SYNC_W.
  function automatic logic [SYNC_CNT_W-1:0] sync_len(input logic [SYNC_W-1:0] code);
    if (code == '0) return SYNC_CNT_W'(1 << SYNC_W);
    return SYNC_CNT_W'(code);
  endfunction

endpackage

// File: rtl/crt_hcount.sv
module crt_hcount
  import crt_timing_pkg::*;
#(
  parameter int H_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [H_W-1:0]    h_total,
  input  logic [H_W-1:0]    h_disp,
  input  logic [H_W-1:0]    hs_pos,
  input  logic [SYNC_W-1:0] hs_width,
  output logic              line_end,
  output logic              h_active,
  output logic              hs_now,
  output logic              second_half
);

  logic [H_W-1:0]        hcnt;
  logic [SYNC_CNT_W-1:0] hs_left;
  logic [H_W:0]          half_pos;

  assign line_end    = (hcnt == h_total);
  assign h_active    = (hcnt < h_disp);
  assign hs_now      = (hcnt == hs_pos) || (hs_left != '0);
  assign half_pos    = ({1'b0, h_total} + (H_W+1)'(1)) >> 1;
  assign second_half = ({1'b0, hcnt} >= half_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      hs_left <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + H_W'(1);
      if (hcnt == hs_pos)
        hs_left <= sync_len(hs_width) - SYNC_CNT_W'(1);
      else if (hs_left != '0)
        hs_left <= hs_left - SYNC_CNT_W'(1);
    end
  end

  // R1: the counter returns to position 0 after the last character
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hcnt == '0));

  // R2: the remaining-width counter never exceeds the longest pulse
  a_r2_hs_left_range: assert property (@(posedge clk) disable iff (rst)
    hs_left < SYNC_CNT_W'(1 << SYNC_W));

endmodule

// File: rtl/crt_vcount.sv
module crt_vcount
  import crt_timing_pkg::*;
#(
  parameter int V_W  = 7,
  parameter int RA_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_end,
  input  logic              second_half,
  input  logic [V_W-1:0]    v_total,
  input  logic [V_W-1:0]    v_disp,
  input  logic [V_W-1:0]    vs_pos,
  input  logic [RA_W-1:0]   row_max,
  input  logic [RA_W-1:0]   v_adj,
  input  logic [SYNC_W-1:0] vs_width,
  input  logic [1:0]        scan_mode,
  output logic [RA_W-1:0]   ra,
  output logic              row_done,
  output logic              frame_end,
  output logic              v_active,
  output logic              vs_now
);

  logic [V_W-1:0]        vrow;
  logic                  in_adj;
  logic                  field;
  logic [SYNC_CNT_W-1:0] vs_left;
  logic                  vs_prev;
  logic                  video, ilace;
  logic [RA_W-1:0]       ra_init;
  logic                  row_last, at_bottom, adj_last, next_field;
  logic                  vs_start, vs_line;

  assign video      = (scan_mode == SCAN_ILACE_VIDEO);
  assign ilace      = scan_mode[0];
  assign ra_init    = RA_W'(video & field);
  assign row_last   = video ? (({1'b0, ra} + (RA_W+1)'(1)) >= {1'b0, row_max})
                            : (ra == row_max);
  assign at_bottom  = !in_adj && row_last && (vrow == v_total);
  assign adj_last   = in_adj && (({1'b0, ra} + (RA_W+1)'(1)) == {1'b0, v_adj});
  assign frame_end  = line_end && ((at_bottom && (v_adj == '0)) || adj_last);
  assign row_done   = !in_adj && row_last;
  assign next_field = ilace & ~field;
  assign v_active   = !in_adj && (vrow < v_disp);

  assign vs_start = !in_adj && (vrow == vs_pos) && (ra == ra_init);
  assign vs_line  = vs_start || (vs_left != '0);
  assign vs_now   = (ilace && field) ? (second_half ? vs_line : vs_prev) : vs_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      ra      <= '0;
      vrow    <= '0;
      in_adj  <= 1'b0;
      field   <= 1'b0;
      vs_left <= '0;
      vs_prev <= 1'b0;
    end else if (line_end) begin
      vs_prev <= vs_line;
      if (vs_start)
        vs_left <= sync_len(vs_width) - SYNC_CNT_W'(1);
      else if (vs_left != '0)
        vs_left <= vs_left - SYNC_CNT_W'(1);

      if (frame_end) begin
        vrow   <= '0;
        in_adj <= 1'b0;
        field  <= next_field;
        ra     <= RA_W'(video & next_field);
      end else if (at_bottom) begin
        in_adj <= 1'b1;
        ra     <= '0;
      end else if (in_adj) begin
        ra <= ra + RA_W'(1);
      end else if (row_last) begin
        ra   <= ra_init;
        vrow <= vrow + V_W'(1);
      end else begin
        ra <= ra + (video ? RA_W'(2) : RA_W'(1));
      end
    end
  end

  // R3: outside the extra scanlines a progressive row never passes its last scanline
  a_r3_ra_in_row: assert property (@(posedge clk) disable iff (rst)
    (!in_adj && !video) |-> (ra <= row_max));

  // R8: a progressive mode leaves the field at 0 after a frame end
  a_r8_field_progressive: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !ilace) |=> !field);

  // R9: alternate-scanline video keeps the raster parity equal to the field
  a_r9_video_parity: assert property (@(posedge clk) disable iff (rst)
    (video && !in_adj) |-> (ra[0] == field));

endmodule

// File: rtl/crt_addr.sv
module crt_addr #(
  parameter int MA_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MA_W-1:0] start_addr,
  input  logic            h_active,
  input  logic            line_end,
  input  logic            row_done,
  input  logic            frame_end,
  output logic [MA_W-1:0] ma
);

  logic [MA_W-1:0] row_base;
  logic [MA_W-1:0] ma_step;

  assign ma_step = ma + MA_W'(h_active);

  always_ff @(posedge clk) begin
    if (rst) begin
      ma       <= start_addr;
      row_base <= start_addr;
    end else if (line_end) begin
      if (frame_end) begin
        ma       <= start_addr;
        row_base <= start_addr;
      end else if (row_done) begin
        row_base <= ma_step;
        ma       <= ma_step;
      end else begin
        ma <= row_base;
      end
    end else begin
      ma <= ma_step;
    end
  end

  // R6: every frame begins at the programmed start address
  a_r6_frame_reload: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (ma == start_addr));

endmodule

// File: rtl/crt_skew.sv
module crt_skew
  import crt_timing_pkg::*;
#(
  parameter int MAX_SKEW = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       de_raw,
  input  logic [1:0] skew,
  output logic       de_out
);

  logic [MAX_SKEW:1] dly;
  logic              tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly <= '0;
    end else begin
      dly[1] <= de_raw;
      for (int i = 2; i <= MAX_SKEW; i++) dly[i] <= dly[i-1];
    end
  end

  always_comb begin
    tap = de_raw;
    for (int i = 1; i <= MAX_SKEW; i++)
      if (int'(skew) == i) tap = dly[i];
    if (skew == SKEW_BLANK) tap = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) de_out <= 1'b0;
    else     de_out <= tap;
  end

  // R7: the blanking code keeps the display off
  a_r7_skew_blank: assert property (@(posedge clk) disable iff (rst)
    (skew == SKEW_BLANK) |=> !de_out);

endmodule

// File: rtl/char_raster_timer.sv
module char_raster_timer
  import crt_timing_pkg::*;
#(
  parameter int H_W      = 8,
  parameter int V_W      = 7,
  parameter int RA_W     = 5,
  parameter int MA_W     = 14,
  parameter int MAX_SKEW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [H_W-1:0]    cfg_h_total,
  input  logic [H_W-1:0]    cfg_h_disp,
  input  logic [H_W-1:0]    cfg_hs_pos,
  input  logic [SYNC_W-1:0] cfg_hs_width,
  input  logic [SYNC_W-1:0] cfg_vs_width,
  input  logic [V_W-1:0]    cfg_v_total,
  input  logic [V_W-1:0]    cfg_v_disp,
  input  logic [V_W-1:0]    cfg_vs_pos,
  input  logic [RA_W-1:0]   cfg_row_max,
  input  logic [RA_W-1:0]   cfg_v_adj,
  input  logic [1:0]        cfg_skew,
  input  logic [1:0]        cfg_scan_mode,
  input  logic [MA_W-1:0]   cfg_start_addr,
  output logic              hsync,
  output logic              vsync,
  output logic              disp_en,
  output logic [RA_W-1:0]   ras_addr,
  output logic [MA_W-1:0]   mem_addr
);

  logic            line_end, h_active, hs_now, second_half;
  logic [RA_W-1:0] ra;
  logic            row_done, frame_end, v_active, vs_now;
  logic [MA_W-1:0] ma;

  crt_hcount #(.H_W(H_W)) u_hcount (
    .clk(clk), .rst(rst),
    .h_total(cfg_h_total), .h_disp(cfg_h_disp),
    .hs_pos(cfg_hs_pos), .hs_width(cfg_hs_width),
    .line_end(line_end), .h_active(h_active),
    .hs_now(hs_now), .second_half(second_half)
  );

  crt_vcount #(.V_W(V_W), .RA_W(RA_W)) u_vcount (
    .clk(clk), .rst(rst),
    .line_end(line_end), .second_half(second_half),
    .v_total(cfg_v_total), .v_disp(cfg_v_disp), .vs_pos(cfg_vs_pos),
    .row_max(cfg_row_max), .v_adj(cfg_v_adj), .vs_width(cfg_vs_width),
    .scan_mode(cfg_scan_mode),
    .ra(ra), .row_done(row_done), .frame_end(frame_end),
    .v_active(v_active), .vs_now(vs_now)
  );

  crt_addr #(.MA_W(MA_W)) u_addr (
    .clk(clk), .rst(rst),
    .start_addr(cfg_start_addr), .h_active(h_active),
    .line_end(line_end), .row_done(row_done), .frame_end(frame_end),
    .ma(ma)
  );

  crt_skew #(.MAX_SKEW(MAX_SKEW)) u_skew (
    .clk(clk), .rst(rst),
    .de_raw(h_active && v_active), .skew(cfg_skew),
    .de_out(disp_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      ras_addr <= '0;
      mem_addr <= '0;
    end else begin
      hsync    <= hs_now;
      vsync    <= vs_now;
      ras_addr <= ra;
      mem_addr <= ma;
    end
  end

  // R10: the output stage follows the address counter by one clock
  a_r10_addr_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mem_addr == $past(ma)));

endmodule

// File: tb/test_char_raster_timer.sv
module test_char_raster_timer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int HT, HD, HSP, HSW, VSW, VT, VD, VSP, R, ADJ, SK, MODE, START;

  logic        hsync, vsync, disp_en;
  logic [4:0]  ras_addr;
  logic [13:0] mem_addr;

  char_raster_timer i_char_raster_timer (
    .clk(clk), .rst(rst),
    .cfg_h_total(HT[7:0]), .cfg_h_disp(HD[7:0]), .cfg_hs_pos(HSP[7:0]),
    .cfg_hs_width(HSW[3:0]), .cfg_vs_width(VSW[3:0]),
    .cfg_v_total(VT[6:0]), .cfg_v_disp(VD[6:0]), .cfg_vs_pos(VSP[6:0]),
    .cfg_row_max(R[4:0]), .cfg_v_adj(ADJ[4:0]), .cfg_skew(SK[1:0]),
    .cfg_scan_mode(MODE[1:0]), .cfg_start_addr(START[13:0]),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .ras_addr(ras_addr), .mem_addr(mem_addr)
  );

  typedef struct {
    logic       hs;
    logic       vs;
    logic       de;
    logic [4:0] ra;
    logic [13:0] ma;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  int bh, bl, bfield, bline;
  bit hist[3];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lines_per_row(int f);
    int s, n;
    if (MODE == 3) begin
      s = f; n = 1;
      while (s + 1 < R) begin s += 2; n++; end
      return n;
    end
    return R + 1;
  endfunction

  function automatic int frame_lines(int f);
    return (VT + 1) * lines_per_row(f) + ADJ;
  endfunction

  function automatic bit vs_of_line(int l, int f);
    int w, ls;
    w  = (VSW == 0) ? 16 : VSW;
    ls = VSP * lines_per_row(f);
    return (l >= ls) && (l < ls + w);
  endfunction

  // Driver: predicts the outputs for the current timing position, then advances it.
  task automatic push_expected();
    exp_t e;
    int n, row, ra, hw, d, half;
    bit adj, raw;
    n   = lines_per_row(bfield);
    row = bl / n;
    adj = 1'b0;
    if (row <= VT) ra = (MODE == 3) ? bfield + 2 * (bl % n) : bl % n;
    else begin adj = 1'b1; ra = bl - (VT + 1) * n; row = VT + 1; end
    hw   = (HSW == 0) ? 16 : HSW;
    d    = (bh - HSP + HT + 1) % (HT + 1);
    e.hs = (d < hw) && !(bline == 0 && bh < HSP);
    half = (HT + 1) / 2;
    if ((MODE % 2 == 1) && bfield == 1)
      e.vs = (bh >= half) ? vs_of_line(bl, bfield)
                          : ((bl > 0) ? vs_of_line(bl - 1, bfield) : 1'b0);
    else
      e.vs = vs_of_line(bl, bfield);
    raw = (bh < HD) && (row < VD) && !adj;
    hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = raw;
    e.de = (SK == 3) ? 1'b0 : hist[SK];
    e.ra = ra[4:0];
    e.ma = 14'((START + row * HD + ((bh < HD) ? bh : HD)) % 16384);
    q.push_back(e);
    bh++;
    if (bh > HT) begin
      bh = 0; bl++; bline++;
      if (bl == frame_lines(bfield)) begin
        bl = 0;
        if (MODE % 2 == 1) bfield = 1 - bfield;
      end
    end
  endtask

  // Monitor: compares each produced cycle against the oldest prediction.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R2", "hsync", int'(hsync), int'(e.hs));
        chk("R5 R8", "vsync", int'(vsync), int'(e.vs));
        chk("R1 R4 R7", "disp_en", int'(disp_en), int'(e.de));
        chk("R3 R9", "ras_addr", int'(ras_addr), int'(e.ra));
        chk("R6", "mem_addr", int'(mem_addr), int'(e.ma));
      end
    end
  end

  task automatic run_cfg(int cycles);
    rst = 1'b1;
    bh = 0; bl = 0; bfield = 0; bline = 0;
    hist[0] = 1'b0; hist[1] = 1'b0; hist[2] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: all outputs are zero while reset is held
    chk("R10", "reset hsync", int'(hsync), 0);
    chk("R10", "reset vsync", int'(vsync), 0);
    chk("R10", "reset disp_en", int'(disp_en), 0);
    chk("R10", "reset ras_addr", int'(ras_addr), 0);
    chk("R10", "reset mem_addr", int'(mem_addr), 0);
    rst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #1;
      push_expected();
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired before the run ended");
    finish_run();
  end

  initial begin
    // A: progressive, hsync wraps across the line end, extra scanlines, address wrap (R1 R3 R6)
    HT = 9; HD = 6; HSP = 7; HSW = 4; VSW = 2; VT = 3; VD = 2; VSP = 3;
    R = 2; ADJ = 2; SK = 0; MODE = 0; START = 14'h3FFC;
    run_cfg(300);
    // B: width code 0 on both syncs, skew 1, mode 10 progressive (R2 R5 R7 R8)
    HT = 20; HD = 12; HSP = 10; HSW = 0; VSW = 0; VT = 4; VD = 3; VSP = 1;
    R = 3; ADJ = 0; SK = 1; MODE = 2; START = 14'h0040;
    run_cfg(860);
    // C: interlace with half-line vsync in field 1, skew 2 (R8 R7)
    HT = 11; HD = 8; HSP = 9; HSW = 3; VSW = 3; VT = 3; VD = 3; VSP = 2;
    R = 1; ADJ = 1; SK = 2; MODE = 1; START = 14'h0200;
    run_cfg(340);
    // D: interlace with alternate scanlines, skew code 3 blanks (R9 R7 R4)
    HT = 7; HD = 5; HSP = 5; HSW = 2; VSW = 1; VT = 2; VD = 2; VSP = 1;
    R = 4; ADJ = 1; SK = 3; MODE = 3; START = 14'h0100;
    run_cfg(290);
    finish_run();
  end

endmodule